// File: doc/BRIEF.md
# Masked Operand Address Generator

This block forms the memory operand address for multiply-accumulate instructions that read a memory operand. It takes the current value of an address register, a two-bit addressing-mode code, a 16-bit displacement and a mask-select flag from the instruction extension word. It returns the operand address. For the auto-update modes it also returns the new address-register value and a write-back strobe. All address results are combinational.

When the mask-select flag is set, each computed address and each written-back register value is ANDed with a 32-bit mask word. The upper half of that word is all ones and the lower half comes from a programmable 16-bit mask register. A power-of-two buffer can therefore be walked with post-increment or pre-decrement, and the register wraps inside the buffer with no software help.

The mask register has a simple synchronous write port and a combinational read port. A read returns all 32 bits, with the upper half fixed at ones.

Top module: `masked_agu`

## Requirements
- R1: With mode 2'b00 (register indirect), op_addr equals areg_in ANDed with the mask word, areg_we is 0 and areg_new equals areg_in.
- R2: With mode 2'b01 (post-increment), op_addr equals areg_in unmasked, areg_we is 1 and areg_new equals (areg_in + 4) ANDed with the mask word.
- R3: With mode 2'b10 (pre-decrement), both op_addr and areg_new equal (areg_in - 4) ANDed with the mask word, and areg_we is 1.
- R4: With mode 2'b11 (displacement), op_addr equals (areg_in + disp sign-extended to 32 bits) ANDed with the mask word, areg_we is 0 and areg_new equals areg_in.
- R5: When mask_en is 0, no masking is applied in any mode: the mask word acts as all ones.
- R6: The mask word is {16'hFFFF, mask register}, so bits 31..16 of any masked result equal the unmasked bits.
- R7: After reset, mreg_rd_data reads 32'hFFFF_FFFF.
- R8: mreg_rd_data[31:16] always reads 16'hFFFF and ignores written data; bits 15..0 read back the last value written.
- R9: A mask write is applied at the clock edge. Address results in the cycle of the write still use the old mask, and results from the next cycle on use the new mask.
- R10: Address arithmetic wraps modulo 2^32 with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreg_wr_en | input | 1 | Mask register write strobe |
| mreg_wr_data | input | 32 | Mask register write data (bits 15..0 used) |
| mreg_rd_data | output | 32 | Mask register read data |
| areg_in | input | 32 | Current address-register value |
| amode | input | 2 | Addressing mode: 00 indirect, 01 post-inc, 10 pre-dec, 11 displacement |
| disp | input | 16 | Signed displacement |
| mask_en | input | 1 | Mask select from the extension word |
| op_addr | output | 32 | Operand address |
| areg_new | output | 32 | Updated address-register value |
| areg_we | output | 1 | Address-register write-back strobe |

## Verification
On every cycle the assertions check these properties: write-back is suppressed in indirect and displacement modes, post-increment passes the register through unchanged as the address, and pre-decrement gives the same address and new register value. They also check that the upper half of the read data stays at ones, that a mask write lands on the next cycle, and that the upper address half survives masking. The exact masked values, the sign extension of negative displacements, wrap-around at the 32-bit boundary and the old-mask behaviour in the cycle of a write can only be shown by the bench's chosen scenarios, because each needs a specific operand pattern.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W = 32;
  localparam int MASK_W = 16;
  localparam int DISP_W = 16;
  localparam int STEP   = 4;
  localparam int HI_W   = ADDR_W - MASK_W;

  typedef enum logic [1:0] {
    AM_IND  = 2'b00,
    AM_POST = 2'b01,
    AM_PRE  = 2'b10,
    AM_DISP = 2'b11
  } amode_e;

  function automatic logic [ADDR_W-1:0] mask_word(input logic [MASK_W-1:0] m,
                                                  input logic en);
    return en ? {{HI_W{1'b1}}, m} : {ADDR_W{1'b1}};
  endfunction

  function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic down);
    return down ? a - ADDR_W'(STEP) : a + ADDR_W'(STEP);
  endfunction
endpackage

// File: rtl/agu_mask_reg.sv
module agu_mask_reg
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [MASK_W-1:0] mask_q,
  output logic [ADDR_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= {MASK_W{1'b1}};
    else if (wr_en) mask_q <= wr_data[MASK_W-1:0];
  end

  assign rd_data = {{HI_W{1'b1}}, mask_q};

  a_r8_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ADDR_W-1:MASK_W] == {HI_W{1'b1}});

  a_r9_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[MASK_W-1:0] == $past(wr_data[MASK_W-1:0]));
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
(
  input  logic [ADDR_W-1:0] areg_in,
  input  logic [1:0]        amode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] mword,
  output logic [ADDR_W-1:0] op_addr,
  output logic [ADDR_W-1:0] areg_new,
  output logic              areg_we
);
  logic [ADDR_W-1:0] inc_val, dec_val, disp_sum;

  assign inc_val  = step_addr(areg_in, 1'b0);
  assign dec_val  = step_addr(areg_in, 1'b1);
  assign disp_sum = areg_in + sext_disp(disp);

  always_comb begin
    op_addr  = areg_in & mword;
    areg_new = areg_in;
    areg_we  = 1'b0;
    case (amode_e'(amode))
      AM_IND:  op_addr = areg_in & mword;
      AM_POST: begin
        op_addr  = areg_in;
        areg_new = inc_val & mword;
        areg_we  = 1'b1;
      end
      AM_PRE: begin
        op_addr  = dec_val & mword;
        areg_new = dec_val & mword;
        areg_we  = 1'b1;
      end
      AM_DISP: op_addr = disp_sum & mword;
      default: ;
    endcase
  end
endmodule

// File: rtl/masked_agu.sv
module masked_agu
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mreg_wr_en,
  input  logic [31:0] mreg_wr_data,
  output logic [31:0] mreg_rd_data,
  input  logic [31:0] areg_in,
  input  logic [1:0]  amode,
  input  logic [15:0] disp,
  input  logic        mask_en,
  output logic [31:0] op_addr,
  output logic [31:0] areg_new,
  output logic        areg_we
);
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:0] mword;

  agu_mask_reg u_mreg (
    .clk(clk), .rst_n(rst_n), .wr_en(mreg_wr_en), .wr_data(mreg_wr_data),
    .mask_q(mask_q), .rd_data(mreg_rd_data)
  );

  assign mword = mask_word(mask_q, mask_en);

  agu_addr_calc u_calc (
    .areg_in(areg_in), .amode(amode), .disp(disp), .mword(mword),
    .op_addr(op_addr), .areg_new(areg_new), .areg_we(areg_we)
  );

  a_r1_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (amode == 2'b00 || amode == 2'b11) |-> (!areg_we && areg_new == areg_in));

  a_r2_post_raw: assert property (@(posedge clk) disable iff (!rst_n)
    amode == 2'b01 |-> (op_addr == areg_in && areg_we));

  a_r3_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
    amode == 2'b10 |-> (op_addr == areg_new && areg_we));

  a_r5_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_en && amode == 2'b00) |-> op_addr == areg_in);

  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    amode == 2'b00 |-> op_addr[31:16] == areg_in[31:16]);
endmodule

// File: tb/tb_masked_agu.sv
`timescale 1ns/1ps
module tb_masked_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreg_wr_en = 1'b0;
  logic [31:0] mreg_wr_data = '0;
  logic [31:0] mreg_rd_data;
  logic [31:0] areg_in = '0;
  logic [1:0]  amode = 2'b00;
  logic [15:0] disp = '0;
  logic        mask_en = 1'b0;
  logic [31:0] op_addr, areg_new;
  logic        areg_we;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mdl_mask = 16'hFFFF;

  typedef struct {
    bit          is_rd;
    logic [31:0] oa, na, rd;
    logic        we;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  masked_agu dut (.*);

  function automatic logic [31:0] mk(input logic en);
    logic [31:0] m;
    m = 32'hFFFF_FFFF;
    if (en) m[15:0] = mdl_mask;
    return m;
  endfunction

  task automatic drive(input logic [1:0] md, input logic [31:0] a,
                       input logic [15:0] d, input logic en, input string req);
    exp_t e;
    logic [31:0] m, sd;
    m  = mk(en);
    sd = {{16{d[15]}}, d};
    amode = md; areg_in = a; disp = d; mask_en = en;
    e.is_rd = 0; e.req = req; e.rd = '0;
    case (md)
      2'b00: begin e.oa = a & m;           e.na = a;               e.we = 0; end
      2'b01: begin e.oa = a;               e.na = (a + 32'd4) & m; e.we = 1; end
      2'b10: begin e.oa = (a - 32'd4) & m; e.na = (a - 32'd4) & m; e.we = 1; end
      default: begin e.oa = (a + sd) & m;  e.na = a;               e.we = 0; end
    endcase
    q.push_back(e);
  endtask

  task automatic apply(input logic [1:0] md, input logic [31:0] a,
                       input logic [15:0] d, input logic en, input string req);
    @(negedge clk);
    drive(md, a, d, en, req);
  endtask

  task automatic expect_rd(input logic [31:0] v, input string req);
    exp_t e;
    @(negedge clk);
    e.is_rd = 1; e.rd = v; e.req = req; e.oa = '0; e.na = '0; e.we = 0;
    q.push_back(e);
  endtask

  task automatic write_mask(input logic [31:0] v, input logic [1:0] md,
                            input logic [31:0] a, input string req);
    @(negedge clk);
    mreg_wr_en = 1'b1; mreg_wr_data = v;
    drive(md, a, 16'h0, 1'b1, req);
    @(posedge clk);
    mdl_mask = v[15:0];
    @(negedge clk);
    mreg_wr_en = 1'b0;
    drive(md, a, 16'h0, 1'b1, req);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (e.is_rd) begin
          if (mreg_rd_data !== e.rd) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", e.req, mreg_rd_data, e.rd);
          end
        end else if (op_addr !== e.oa || areg_new !== e.na || areg_we !== e.we) begin
          n_bad++;
          $display("FAIL %s actual oa=%h na=%h we=%b expected oa=%h na=%h we=%b",
                   e.req, op_addr, areg_new, areg_we, e.oa, e.na, e.we);
        end
      end
    end
  end

  initial begin : watchdog
    #80000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(32'hFFFF_FFFF, "R7");
    apply(2'b00, 32'hABCD_1234, 16'h0, 1'b1, "R7 reset mask all ones");
    // R9: write lands next cycle; R8 upper bits ignore write data
    write_mask(32'h1234_00FF, 2'b00, 32'hABCD_1234, "R9");
    expect_rd(32'hFFFF_00FF, "R8");
    apply(2'b00, 32'hABCD_1234, 16'h0, 1'b1, "R1");
    apply(2'b00, 32'h5555_AAAA, 16'h0, 1'b1, "R6");
    apply(2'b01, 32'h1000_00FC, 16'h0, 1'b1, "R2 wrap in buffer");
    apply(2'b01, 32'h1000_0010, 16'h0, 1'b1, "R2");
    apply(2'b10, 32'h2000_0000, 16'h0, 1'b1, "R3");
    apply(2'b10, 32'h2000_0108, 16'h0, 1'b1, "R3");
    apply(2'b11, 32'h3000_0105, 16'hFFF0, 1'b1, "R4 negative disp");
    apply(2'b11, 32'h3000_0105, 16'h0010, 1'b0, "R4 unmasked");
    apply(2'b11, 32'h0000_7FF0, 16'h7FFF, 1'b1, "R4 positive disp");
    apply(2'b00, 32'hABCD_1234, 16'h0, 1'b0, "R5");
    apply(2'b01, 32'h1000_00FC, 16'h0, 1'b0, "R5");
    apply(2'b10, 32'h2000_0000, 16'h0, 1'b0, "R5");
    apply(2'b01, 32'hFFFF_FFFC, 16'h0, 1'b0, "R10");
    apply(2'b10, 32'h0000_0000, 16'h0, 1'b0, "R10");
    apply(2'b11, 32'hFFFF_FFF0, 16'h0020, 1'b0, "R10");
    write_mask(32'h0000_F0F0, 2'b10, 32'h4000_0000, "R9");
    expect_rd(32'hFFFF_F0F0, "R8");
    repeat (2) @(negedge clk);
    disable watchdog;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule